// File: doc/BRIEF.md
# Shared-Vector External Interrupt Request Selector

This block turns six external interrupt pins and four internal peripheral event pulses into six interrupt request flags for a small interrupt controller. Four request slots belong to pins 0 to 3. The two remaining slots are shared. Slot 4 is driven by pin 4 or by a group made of a transmit-done event and a serial-channel-3 event. Slot 5 is driven by pin 5 or by a group made of a receive-done event and a serial-channel-4 event.

Each pin can detect a single edge or both edges. In single-edge mode a polarity input chooses between the falling and the rising edge. Two byte-wide cause-select registers choose the source of each shared slot in two levels: first pin or group, then which group member. Software writes these registers over a simple write-only byte bus. A request flag stays set until a per-slot acknowledge strobe clears it. Priority resolution, vector fetch and the peripherals themselves sit outside this block.

Pins pass through a two-flop synchronizer and an edge register. A pin change therefore raises its flag on the third rising clock edge after the pin changes. An internal event pulse raises its flag on the first rising edge that samples it.

Top module: `irq_cause_sel`

## Requirements
- R1: After reset every request flag is 0 and both cause-select registers read as 0x00. All pins are in single-edge mode, slot 4 follows the transmit-done event, and slot 5 follows the receive-done event.
- R2: In single-edge mode (primary register bit i = 0 for pin i), a polarity bit of 0 requests only on a falling pin edge, and a polarity bit of 1 requests only on a rising pin edge. The flag is still 0 two rising clock edges after the pin change and is 1 after the third.
- R3: In both-edge mode (primary register bit i = 1), every pin transition raises the slot's flag, whatever the polarity bit holds.
- R4: Primary register bit 6 selects the source of slot 4: 1 for pin 4, 0 for the internal group. Events from the source that is not selected have no effect on the flag.
- R5: Primary register bit 7 selects the source of slot 5: 1 for pin 5, 0 for the internal group. Events from the source that is not selected have no effect on the flag.
- R6: While slot 4 uses the group, secondary register bit 0 picks the member: 0 for the transmit-done event, 1 for the serial-3 event.
- R7: While slot 5 uses the group, secondary register bit 3 picks the member: 0 for the receive-done event, 1 for the serial-4 event.
- R8: A request flag holds until the acknowledge bit of its slot is sampled high, and it reads 0 after that edge. If a set and an acknowledge for the same slot land on the same edge, the flag stays set. An acknowledge for another slot leaves the flag unchanged.
- R9: A write to a select or mode bit, or a change on a polarity input, never sets a flag by itself. A new register value takes effect from the clock edge after the one that writes it. An event sampled on the writing edge is still routed by the old value.
- R10: An internal event held high for one clock sets its selected flag on that same rising edge.
- R11: With the write enable high, address 0 writes the primary register and address 1 writes the secondary register. With the write enable low, neither register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = primary cause-select, 1 = secondary cause-select |
| reg_wdata | input | 8 | Register write data |
| pin_in | input | 6 | External interrupt pins, asynchronous |
| pin_pol | input | 6 | Per-slot polarity in single-edge mode: 0 falling, 1 rising |
| evt_tx_done | input | 1 | Transmit-done event pulse |
| evt_ser3 | input | 1 | Serial-3 event pulse |
| evt_rx_done | input | 1 | Receive-done event pulse |
| evt_ser4 | input | 1 | Serial-4 event pulse |
| irq_ack | input | 6 | Per-slot request acknowledge strobes |
| irq_req | output | 6 | Per-slot request flags |

## Verification
A corrupted synchronizer or edge register shows at the ports as a flag that rises one clock early or late, or that rises on the wrong edge. The bench checks both the quiet second edge and the third edge. A wrong bit in either cause-select register routes an event to the wrong shared slot, or drops it. That error is visible on the first rising edge after the event. A fault in the flag logic shows as a flag that clears without an acknowledge, survives one, or loses a set that coincides with one. Each of these is visible on the edge that follows the strobe.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int N_PINS      = 6;
    localparam int N_SLOTS     = N_PINS;
    localparam int SLOT_A      = N_PINS - 2;
    localparam int SLOT_B      = N_PINS - 1;
    localparam int N_DEDICATED = N_PINS - 2;
    localparam int DATA_W      = 8;
    localparam int PRI_SEL_A   = 6;
    localparam int PRI_SEL_B   = 7;
    localparam int SEC_PICK_A  = 0;
    localparam int SEC_PICK_B  = 3;

    typedef struct packed {
        logic [N_PINS-1:0] both_edge;
        logic              a_from_pin;
        logic              b_from_pin;
        logic              a_pick_ser;
        logic              b_pick_ser;
    } cause_cfg_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int N_PINS      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] both_edge,
    input  logic [N_PINS-1:0] pin_pol,
    output logic [N_PINS-1:0] edge_evt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][N_PINS-1:0] sync;
        logic [N_PINS-1:0]                  last;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [N_PINS-1:0] settled, rise, fall;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin_in;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            st_d.sync[k] = st_q.sync[k-1];
        end
        st_d.last = st_q.sync[SYNC_STAGES-1];
    end

    // idle-high reset avoids a false falling edge on pins that rest high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign settled  = st_q.sync[SYNC_STAGES-1];
    assign rise     = settled & ~st_q.last;
    assign fall     = ~settled & st_q.last;
    assign edge_evt = (both_edge & (rise | fall))
                    | (~both_edge & pin_pol & rise)
                    | (~both_edge & ~pin_pol & fall);
endmodule

// File: rtl/irq_src_mux.sv
module irq_src_mux
    import irq_sel_pkg::*;
(
    input  logic [N_PINS-1:0]  pin_evt,
    input  cause_cfg_t         cfg,
    input  logic               evt_tx_done,
    input  logic               evt_ser3,
    input  logic               evt_rx_done,
    input  logic               evt_ser4,
    output logic [N_SLOTS-1:0] slot_set
);
    logic grp_a, grp_b;

    genvar g;
    generate
        for (g = 0; g < N_DEDICATED; g++) begin : g_ded
            assign slot_set[g] = pin_evt[g];
        end
    endgenerate

    assign grp_a = cfg.a_pick_ser ? evt_ser3 : evt_tx_done;
    assign grp_b = cfg.b_pick_ser ? evt_ser4 : evt_rx_done;

    assign slot_set[SLOT_A] = cfg.a_from_pin ? pin_evt[SLOT_A] : grp_a;
    assign slot_set[SLOT_B] = cfg.b_from_pin ? pin_evt[SLOT_B] : grp_b;
endmodule

// File: rtl/irq_cause_sel.sv
module irq_cause_sel
    import irq_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [N_PINS-1:0]  pin_in,
    input  logic [N_PINS-1:0]  pin_pol,
    input  logic               evt_tx_done,
    input  logic               evt_ser3,
    input  logic               evt_rx_done,
    input  logic               evt_ser4,
    input  logic [N_SLOTS-1:0] irq_ack,
    output logic [N_SLOTS-1:0] irq_req
);
    typedef struct packed {
        cause_cfg_t         cfg;
        logic [N_SLOTS-1:0] req;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [N_PINS-1:0]  pin_evt;
    logic [N_SLOTS-1:0] slot_set;

    irq_pin_edge #(
        .N_PINS      (N_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .both_edge (st_q.cfg.both_edge),
        .pin_pol   (pin_pol),
        .edge_evt  (pin_evt)
    );

    irq_src_mux u_mux (
        .pin_evt     (pin_evt),
        .cfg         (st_q.cfg),
        .evt_tx_done (evt_tx_done),
        .evt_ser3    (evt_ser3),
        .evt_rx_done (evt_rx_done),
        .evt_ser4    (evt_ser4),
        .slot_set    (slot_set)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            if (reg_addr == 1'b0) begin
                st_d.cfg.both_edge  = reg_wdata[N_PINS-1:0];
                st_d.cfg.a_from_pin = reg_wdata[PRI_SEL_A];
                st_d.cfg.b_from_pin = reg_wdata[PRI_SEL_B];
            end else begin
                st_d.cfg.a_pick_ser = reg_wdata[SEC_PICK_A];
                st_d.cfg.b_pick_ser = reg_wdata[SEC_PICK_B];
            end
        end
        // a set on the same edge as an acknowledge wins
        st_d.req = (st_q.req & ~irq_ack) | slot_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req = st_q.req;

    genvar s;
    generate
        for (s = 0; s < N_SLOTS; s++) begin : g_chk
            AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_req[s] && !irq_ack[s]) |=> irq_req[s]);            // R8
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                slot_set[s] |=> irq_req[s]);                            // R8
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_ack[s] && !slot_set[s]) |=> !irq_req[s]);          // R8
            AST_REQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_req[s]) |-> $past(slot_set[s]));              // R9
        end
    endgenerate

    AST_SLOT_A_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.a_from_pin && !pin_evt[SLOT_A]) |-> !slot_set[SLOT_A]); // R4
    AST_SLOT_B_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.b_from_pin && !pin_evt[SLOT_B]) |-> !slot_set[SLOT_B]); // R5
endmodule

// File: tb/irq_cause_sel_test.sv
module irq_cause_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [5:0] pin_in = '1;
    logic [5:0] pin_pol = '0;
    logic       evt_tx_done = 1'b0, evt_ser3 = 1'b0, evt_rx_done = 1'b0, evt_ser4 = 1'b0;
    logic [5:0] irq_ack = '0;
    logic [5:0] irq_req;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    irq_cause_sel uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pin_in(pin_in), .pin_pol(pin_pol),
        .evt_tx_done(evt_tx_done), .evt_ser3(evt_ser3),
        .evt_rx_done(evt_rx_done), .evt_ser4(evt_ser4),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [5:0] exp);
        checks++;
        if (irq_req !== exp) begin
            errors++;
            $display("FAIL %s: irq_req=%b expected %b", tag, irq_req, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); irq_ack = '1;
        @(negedge clk); irq_ack = '0;
    endtask

    task automatic pulse(input int e);
        @(negedge clk);
        case (e)
            0: evt_tx_done = 1'b1;
            1: evt_ser3    = 1'b1;
            2: evt_rx_done = 1'b1;
            default: evt_ser4 = 1'b1;
        endcase
        @(negedge clk);
        {evt_tx_done, evt_ser3, evt_rx_done, evt_ser4} = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(4);

        // R1: reset state and default routing
        check("R1 reset flags", 6'b0);
        pulse(0); check("R1 slot4 default transmit-done", 6'b010000);
        pulse(2); check("R1 slot5 default receive-done", 6'b110000);
        clear_all();
        pin_in[0] = 1'b0; cycles(3); check("R1 pin0 falling default", 6'b000001);
        clear_all();
        pin_in[0] = 1'b1; cycles(4); check("R1 pin0 rising ignored", 6'b0);

        // R2 R3: sweep pin, mode, polarity and edge direction
        for (int i = 0; i < 6; i++) begin
            for (int mode = 0; mode < 2; mode++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int dir = 0; dir < 2; dir++) begin
                        logic fire;
                        write_reg(1'b0, 8'hC0 | (8'(mode) << i));
                        pin_pol = 6'(p) << i;
                        if (dir == 1) begin
                            @(negedge clk); pin_in[i] = 1'b0;
                            cycles(4);
                        end
                        clear_all();
                        fire = (mode == 1) ? 1'b1 : ((p == 1) ? (dir == 1) : (dir == 0));
                        @(negedge clk); pin_in[i] = (dir == 1);
                        cycles(2);
                        check("R2 flag quiet two edges after pin change", 6'b0);
                        cycles(1);
                        check(mode == 1 ? "R3 both-edge sweep" : "R2 single-edge sweep",
                              fire ? (6'b1 << i) : 6'b0);
                        @(negedge clk); pin_in[i] = 1'b1;
                        cycles(4);
                        clear_all();
                        pin_pol = '0;
                    end
                end
            end
        end

        // R4 R5 R6 R7 R10: shared slot routing sweep
        write_reg(1'b0, 8'h00);
        for (int c = 0; c < 16; c++) begin
            logic sa, sb, pa, pb;
            sa = c[0]; sb = c[1]; pa = c[2]; pb = c[3];
            write_reg(1'b0, {sb, sa, 6'b0});
            write_reg(1'b1, {4'b0, pb, 2'b0, pa});
            clear_all();
            for (int e = 0; e < 4; e++) begin
                logic ea, eb;
                ea = !sa && (pa ? (e == 1) : (e == 0));
                eb = !sb && (pb ? (e == 3) : (e == 2));
                pulse(e);
                check("R4 R5 R6 R7 R10 group event routing", {eb, ea, 4'b0});
                clear_all();
            end
            @(negedge clk); pin_in[5:4] = 2'b00;
            cycles(3);
            check("R4 R5 pin source routing", {sb, sa, 4'b0});
            @(negedge clk); pin_in[5:4] = 2'b11;
            cycles(4);
            clear_all();
        end

        // R8: hold, simultaneous set and acknowledge, foreign acknowledge
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h00);
        clear_all();
        pulse(0);
        cycles(5);
        check("R8 flag holds without ack", 6'b010000);
        @(negedge clk); irq_ack = 6'b000001;
        @(negedge clk); irq_ack = '0;
        check("R8 other slot ack leaves flag", 6'b010000);
        @(negedge clk); irq_ack = 6'b010000; evt_tx_done = 1'b1;
        @(negedge clk); irq_ack = '0; evt_tx_done = 1'b0;
        check("R8 set beats ack on same edge", 6'b010000);
        @(negedge clk); irq_ack = 6'b010000;
        @(negedge clk); irq_ack = '0;
        check("R8 ack clears flag", 6'b0);

        // R9: config and polarity changes set nothing
        write_reg(1'b0, 8'hFF);
        write_reg(1'b1, 8'hFF);
        write_reg(1'b0, 8'h3F);
        write_reg(1'b1, 8'h00);
        @(negedge clk); pin_pol = '1;
        @(negedge clk); pin_pol = '0;
        cycles(3);
        check("R9 writes and polarity change set no flag", 6'b0);
        // R9: event on the writing edge uses the old routing
        write_reg(1'b0, 8'h00);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h40; evt_tx_done = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; evt_tx_done = 1'b0;
        check("R9 event on writing edge uses old select", 6'b010000);
        clear_all();
        pulse(0);
        check("R9 new select active next edge", 6'b0);

        // R11: write enable low and address decode
        write_reg(1'b0, 8'h00);
        @(negedge clk); reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = 8'hFF;
        @(negedge clk);
        pulse(0);
        check("R11 write with enable low ignored", 6'b010000);
        clear_all();
        write_reg(1'b1, 8'hC0);
        pulse(0);
        check("R11 secondary write leaves primary", 6'b010000);
        clear_all();
        write_reg(1'b1, 8'h01);
        pulse(1);
        check("R11 R6 secondary write picks serial-3", 6'b010000);
        clear_all();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule